// File: doc/BRIEF.md
# Complementary PWM Pair With Deadtime

The block is an edge-aligned PWM timer with one output pair: a high-true primary output and its complement. An up-counter runs from a programmable start value to a modulo value and then wraps. The primary output is high from the start of each period until the counter reaches the compare value. The secondary output is the inverse of the primary. A programmable deadtime keeps both outputs low for a set number of ticks around every edge.

The modulo, compare and mask values are written into shadow registers. They move to the active registers only when the counter wraps and a software sync request is pending. The sync request then clears itself. This lets software, or a stream of sample writes, change the waveform without glitches.

A debug input, together with a debug mode field, selects what happens while the chip is halted. The timer can keep running, stop with the outputs held, or stop with the outputs forced low. A one-cycle compare strobe can request the next sample. Everything advances only on cycles where `clk_en` is high.

The sequencer is a three-state machine:
- `ST_IDLE`: the timer is disabled and the counter is held at the start value.
- `ST_RUN`: the counter advances.
- `ST_FROZEN`: the timer is halted by debug.

Its transitions are:
- IDLE→RUN on a tick with `tmr_en` high.
- RUN→FROZEN when a stopping debug mode is active.
- FROZEN→RUN when that halt releases.
- RUN→IDLE and FROZEN→IDLE when `tmr_en` falls.

Top module: `cpwm_pair`

## Requirements
- R1: The counter advances by one only on cycles with `clk_en` high and reloads the start value after equalling the modulo value, so the period is modulo − start + 1 ticks. With `clk_en` low, nothing advances.
- R2: With zero deadtime, `out_hi` is high for clamp(compare − start, 0, period) ticks of each period. It rises at the period start and falls one cycle after the counter equals compare.
- R3: `out_lo` is the complement of the primary waveform with deadtime on both edges. Per period, `out_hi` is high for max(h−D, 0) ticks and `out_lo` for max(period−h−D, 0) ticks, where h is the R2 high time and 0<h<period. The two outputs are never high together.
- R4: The deadtime register (address 4) holds a tick count in bits 5:0 and a scale code in bits 7:6. Codes 00 and 01 scale by 1, code 10 by 4 and code 11 by 16.
- R5: The modulo (address 1), compare (address 2) and mask (address 3) values are shadowed. They reach the active registers only at a wrap that follows a write of 1 to bit 0 of address 6. Without that write they never reach the active registers.
- R6: The sync request clears itself at the wrap where it loads, so later shadow writes stay inactive until a new request.
- R7: Active mask bit 0 forces `out_hi` low and bit 1 forces `out_lo` low.
- R8: The debug mode is bits 1:0 of address 5. While `dbg_req` is high:
  - Mode 11 keeps the timer running.
  - Mode 00 stops the counter and holds the outputs.
  - Modes 01 and 10 stop the counter and force both outputs low.
- R9: `cmp_hit` is high for exactly one tick each time the running counter equals the compare value.
- R10: When disabled, `out_hi` is low and `out_lo` is high. The counter is set to the start value (address 0) on the enabling tick, so the first `cmp_hit` always comes compare − start + 1 cycles after enable. At reset, registers hold start 0, modulo `RST_MOD`, compare 0, mask 0, deadtime 0 and mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Timer tick enable |
| tmr_en | input | 1 | Timer run enable |
| dbg_req | input | 1 | Chip debug halt indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| out_hi | output | 1 | Primary (high-side) output |
| out_lo | output | 1 | Complementary (low-side) output |
| cmp_hit | output | 1 | Compare match strobe |

## Verification
The bench sweeps every compare value from below the start value to above the modulo value. It does this for four start, modulo and deadtime settings that cover each scale code, and checks the high time of both outputs against the arithmetic formulas. A design that counted compare inclusively, or added one tick of deadtime, would be off by one in those counts. A design that reloaded on every shadow write, or kept the sync request pending, would change its duty cycle without a fresh sync. Further checks cover:
- the stop and force behaviour of all four debug modes;
- the pause when `clk_en` is low;
- the fixed phase after enable, which a design that kept its old count across a disable would break.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } tmr_state_e;

    localparam logic [2:0] A_INIT = 3'd0;
    localparam logic [2:0] A_MOD  = 3'd1;
    localparam logic [2:0] A_CMP  = 3'd2;
    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_DEAD = 3'd4;
    localparam logic [2:0] A_DBG  = 3'd5;
    localparam logic [2:0] A_SYNC = 3'd6;

    localparam logic [1:0] DBG_RUN  = 2'b11;
    localparam logic [1:0] DBG_HOLD = 2'b00;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CW      = 16,
    parameter int DCW     = 8,
    parameter int RST_MOD = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic           at_wrap,
    output logic [CW-1:0]  init_val,
    output logic [CW-1:0]  mod_act,
    output logic [CW-1:0]  cmp_act,
    output logic [1:0]     mask_act,
    output logic [DCW-1:0] dead_cfg,
    output logic [1:0]     dbg_mode
);
    logic [CW-1:0] mod_buf, cmp_buf;
    logic [1:0]    mask_buf;
    logic          sync_pend;
    logic          sync_wr;
    logic          do_load;

    assign sync_wr = wr_en && (wr_addr == A_SYNC) && wr_data[0];
    assign do_load = at_wrap && sync_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_val <= '0;
            mod_buf  <= CW'(RST_MOD);
            cmp_buf  <= '0;
            mask_buf <= '0;
            dead_cfg <= '0;
            dbg_mode <= DBG_HOLD;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_INIT:  init_val <= wr_data;
                A_MOD:   mod_buf  <= wr_data;
                A_CMP:   cmp_buf  <= wr_data;
                A_MASK:  mask_buf <= wr_data[1:0];
                A_DEAD:  dead_cfg <= wr_data[DCW-1:0];
                A_DBG:   dbg_mode <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_act   <= CW'(RST_MOD);
            cmp_act   <= '0;
            mask_act  <= '0;
            sync_pend <= 1'b0;
        end else begin
            if (do_load) begin
                mod_act   <= mod_buf;
                cmp_act   <= cmp_buf;
                mask_act  <= mask_buf;
                sync_pend <= 1'b0;
            end
            if (sync_wr) sync_pend <= 1'b1;
        end
    end

    AST_SYNC_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load && !sync_wr) |=> !sync_pend); // R6
    AST_NO_LOAD_WITHOUT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !do_load |=> ($stable(cmp_act) && $stable(mod_act) && $stable(mask_act))); // R5
endmodule

// File: rtl/cpwm_seq.sv
module cpwm_seq
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tmr_en,
    input  logic          halt,
    input  logic [CW-1:0] init_val,
    input  logic [CW-1:0] mod_act,
    input  logic [CW-1:0] cmp_act,
    output logic [CW-1:0] cnt_q,
    output logic          raw_pwm,
    output logic          at_wrap,
    output logic          cmp_hit
);
    tmr_state_e st_q, st_d;
    logic       adv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (tick && tmr_en) st_d = ST_RUN;
            ST_RUN:    if (!tmr_en) st_d = ST_IDLE;
                       else if (halt) st_d = ST_FROZEN;
            ST_FROZEN: if (!tmr_en) st_d = ST_IDLE;
                       else if (!halt) st_d = ST_RUN;
            default:   st_d = ST_IDLE;
        endcase
    end

    assign adv = (st_q == ST_RUN) && tmr_en && tick && !halt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == ST_IDLE || !tmr_en) begin
            cnt_q <= init_val;
        end else if (adv) begin
            cnt_q <= (cnt_q == mod_act) ? init_val : cnt_q + 1'b1;
        end
    end

    always_comb begin
        raw_pwm = (st_q != ST_IDLE) && (cnt_q < cmp_act);
        at_wrap = adv && (cnt_q == mod_act);
        cmp_hit = adv && (cnt_q == cmp_act);
    end

    AST_WRAP_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        at_wrap |=> (cnt_q == $past(init_val))); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q != mod_act) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R1
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FROZEN && tmr_en) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DT_BITS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               raw,
    input  logic [DT_BITS+1:0] dead_cfg,
    output logic               hi_q,
    output logic               lo_q
);
    localparam int LW = DT_BITS + 4;

    logic [LW-1:0] base, dt_len, dly;
    logic          prev;

    assign base = LW'(dead_cfg[DT_BITS-1:0]);

    always_comb begin
        unique case (dead_cfg[DT_BITS+1:DT_BITS])
            2'b10:   dt_len = base << 2;
            2'b11:   dt_len = base << 4;
            default: dt_len = base;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
            hi_q <= 1'b0;
            lo_q <= 1'b0;
            dly  <= '0;
        end else if (tick) begin
            if (raw != prev) begin
                prev <= raw;
                if (dt_len == '0) begin
                    hi_q <= raw;
                    lo_q <= !raw;
                    dly  <= '0;
                end else begin
                    hi_q <= 1'b0;
                    lo_q <= 1'b0;
                    dly  <= dt_len - 1'b1;
                end
            end else if (dly != '0) begin
                dly <= dly - 1'b1;
            end else begin
                hi_q <= prev;
                lo_q <= !prev;
            end
        end
    end

    AST_GAP_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_q) && $past(dt_len) != '0) |-> !$past(lo_q)); // R3
    AST_GAP_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_q) && $past(dt_len) != '0) |-> !$past(hi_q)); // R3
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
    import cpwm_pkg::*;
#(
    parameter int CW      = 16,
    parameter int DT_BITS = 6,
    parameter int RST_MOD = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          tmr_en,
    input  logic          dbg_req,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          out_hi,
    output logic          out_lo,
    output logic          cmp_hit
);
    localparam int DCW = DT_BITS + 2;

    logic [CW-1:0]  init_val, mod_act, cmp_act, cnt_q;
    logic [1:0]     mask_act, dbg_mode;
    logic [DCW-1:0] dead_cfg;
    logic           at_wrap, raw_pwm, halt, force_safe, hi_q, lo_q;

    assign halt       = dbg_req && (dbg_mode != DBG_RUN);
    assign force_safe = halt && (dbg_mode != DBG_HOLD);

    cpwm_regs #(.CW(CW), .DCW(DCW), .RST_MOD(RST_MOD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .at_wrap(at_wrap), .init_val(init_val),
        .mod_act(mod_act), .cmp_act(cmp_act), .mask_act(mask_act),
        .dead_cfg(dead_cfg), .dbg_mode(dbg_mode)
    );

    cpwm_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(clk_en), .tmr_en(tmr_en),
        .halt(halt), .init_val(init_val), .mod_act(mod_act),
        .cmp_act(cmp_act), .cnt_q(cnt_q), .raw_pwm(raw_pwm),
        .at_wrap(at_wrap), .cmp_hit(cmp_hit)
    );

    cpwm_deadband #(.DT_BITS(DT_BITS)) u_dead (
        .clk(clk), .rst_n(rst_n), .tick(clk_en && !halt), .raw(raw_pwm),
        .dead_cfg(dead_cfg), .hi_q(hi_q), .lo_q(lo_q)
    );

    always_comb begin
        out_hi = hi_q && !mask_act[0] && !force_safe;
        out_lo = lo_q && !mask_act[1] && !force_safe;
    end

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hi && out_lo)); // R3
    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && dbg_mode[0] != dbg_mode[1]) |-> (!out_hi && !out_lo)); // R8
endmodule

// File: tb/cpwm_pair_tb.sv
module cpwm_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n, clk_en, tmr_en, dbg_req, wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic        out_hi, out_lo, cmp_hit;
    int          errors = 0;
    int          total = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cpwm_pair #(.CW(16), .DT_BITS(6), .RST_MOD(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tmr_en(tmr_en),
        .dbg_req(dbg_req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_hi(out_hi), .out_lo(out_lo), .cmp_hit(cmp_hit)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int n, output int hc, output int lc, output int bc, output int mc);
        hc = 0; lc = 0; bc = 0; mc = 0;
        repeat (n) begin
            @(negedge clk);
            hc += int'(out_hi);
            lc += int'(out_lo);
            bc += int'(out_hi && out_lo);
            mc += int'(cmp_hit);
        end
    endtask

    task automatic setup(input int ini, input int md, input int cm, input int mk, input int dt);
        wr(3'd0, ini); wr(3'd4, dt); wr(3'd1, md); wr(3'd2, cm); wr(3'd3, mk); wr(3'd6, 1);
        repeat (200) @(negedge clk);
    endtask

    function automatic int dt_ticks(input int dt);
        int c = dt & 63;
        case ((dt >> 6) & 3)
            2:       return c * 4;
            3:       return c * 16;
            default: return c;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; total++;
            $display("FAIL watchdog (all R): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        int ini_a[4] = '{0, 3, 0, 2};
        int mod_a[4] = '{9, 12, 19, 40};
        int dt_a[4]  = '{8'h00, 8'h42, 8'h81, 8'hC1};
        int hc, lc, bc, mc, p, h, d, eh, el, n, gap;
        logic sh, sl;
        rst_n = 1'b0; clk_en = 1'b1; tmr_en = 1'b0; dbg_req = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R10", "reset out_hi", int'(out_hi), 0);
        check("R10", "reset cmp_hit", int'(cmp_hit), 0);
        rst_n = 1'b1;
        tmr_en = 1'b1;

        // R2 R3 R4: sweep every compare value for each configuration
        for (int k = 0; k < 4; k++) begin
            p = mod_a[k] - ini_a[k] + 1;
            d = dt_ticks(dt_a[k]);
            for (int c = (ini_a[k] > 0 ? ini_a[k] - 1 : 0); c <= mod_a[k] + 1; c++) begin
                setup(ini_a[k], mod_a[k], c, 0, dt_a[k]);
                h = c - ini_a[k];
                if (h < 0) h = 0;
                if (h > p) h = p;
                if (h == 0)      begin eh = 0; el = p; end
                else if (h == p) begin eh = p; el = 0; end
                else begin
                    eh = (h > d) ? h - d : 0;
                    el = (p - h > d) ? p - h - d : 0;
                end
                measure(p, hc, lc, bc, mc);
                check(d == 0 ? "R2" : "R4", $sformatf("cfg%0d cmp%0d hi", k, c), hc, eh);
                check("R3", $sformatf("cfg%0d cmp%0d lo", k, c), lc, el);
                check("R3", $sformatf("cfg%0d cmp%0d overlap", k, c), bc, 0);
            end
            // R1 R9: period spacing of the strobe
            setup(ini_a[k], mod_a[k], mod_a[k], 0, dt_a[k]);
            n = 0;
            while (!cmp_hit && n < 100) begin @(negedge clk); n++; end
            gap = 0;
            do begin @(negedge clk); gap++; end while (!cmp_hit && gap < 100);
            check("R1", $sformatf("cfg%0d strobe spacing", k), gap, p);
            measure(4 * p, hc, lc, bc, mc);
            check("R9", $sformatf("cfg%0d strobes in 4 periods", k), mc, 4);
        end

        setup(0, 9, 4, 0, 0);
        // R5: shadow write alone has no effect
        wr(3'd2, 7);
        repeat (100) @(negedge clk);
        measure(10, hc, lc, bc, mc);
        check("R5", "cmp without sync", hc, 4);
        wr(3'd6, 1);
        repeat (100) @(negedge clk);
        measure(10, hc, lc, bc, mc);
        check("R5", "cmp after sync", hc, 7);
        // R6: request cleared after load
        wr(3'd2, 2);
        repeat (100) @(negedge clk);
        measure(10, hc, lc, bc, mc);
        check("R6", "no second load", hc, 7);
        wr(3'd2, 7);

        // R7: masks
        wr(3'd3, 1); wr(3'd6, 1); repeat (100) @(negedge clk);
        measure(10, hc, lc, bc, mc);
        check("R7", "mask0 hi", hc, 0);
        check("R7", "mask0 lo", lc, 3);
        wr(3'd3, 2); wr(3'd6, 1); repeat (100) @(negedge clk);
        measure(10, hc, lc, bc, mc);
        check("R7", "mask1 hi", hc, 7);
        check("R7", "mask1 lo", lc, 0);
        wr(3'd3, 3); wr(3'd6, 1); repeat (100) @(negedge clk);
        measure(10, hc, lc, bc, mc);
        check("R7", "mask both", hc + lc, 0);
        wr(3'd3, 0); wr(3'd6, 1); repeat (100) @(negedge clk);

        // R8: debug modes
        wr(3'd5, 3); dbg_req = 1'b1;
        measure(30, hc, lc, bc, mc);
        check("R8", "mode11 keeps running", mc, 3);
        dbg_req = 1'b0; wr(3'd5, 0); dbg_req = 1'b1;
        repeat (2) @(negedge clk);
        sh = out_hi; sl = out_lo;
        measure(30, hc, lc, bc, mc);
        check("R8", "mode00 stopped", mc, 0);
        check("R8", "mode00 hi held", hc, 30 * int'(sh));
        check("R8", "mode00 lo held", lc, 30 * int'(sl));
        dbg_req = 1'b0; wr(3'd5, 1); dbg_req = 1'b1;
        measure(30, hc, lc, bc, mc);
        check("R8", "mode01 forced low", hc + lc + mc, 0);
        dbg_req = 1'b0; wr(3'd5, 2); dbg_req = 1'b1;
        measure(30, hc, lc, bc, mc);
        check("R8", "mode10 forced low", hc + lc + mc, 0);
        dbg_req = 1'b0;
        measure(30, hc, lc, bc, mc);
        check("R8", "resume after debug", mc, 3);

        // R1: no advance without clock enable
        @(negedge clk); clk_en = 1'b0;
        measure(30, hc, lc, bc, mc);
        check("R1", "clk_en low pauses", mc, 0);
        clk_en = 1'b1;

        // R10: fixed phase after enable
        for (int t = 0; t < 2; t++) begin
            @(negedge clk); tmr_en = 1'b0;
            repeat (20 + 13 * t) @(negedge clk);
            check("R10", "idle out_hi", int'(out_hi), 0);
            check("R10", "idle out_lo", int'(out_lo), 1);
            tmr_en = 1'b1;
            n = 0;
            do begin @(posedge clk); @(negedge clk); n++; end while (!cmp_hit && n < 100);
            check("R10", $sformatf("first strobe after enable t%0d", t), n, 8);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule